// File: doc/BRIEF.md
# Clock Tree Frequency Calculator

This block works out, on request, the frequency in hertz of one branch of a fixed clock tree. It uses the tree's current divider and selector settings, which the block receives as plain input fields. The tree starts from a 24 MHz reference. A PLL multiplies the reference by 20 or 22. Optionally, a fractional stage scales the PLL by 18/frac, and a four-way source selector picks the peripheral root. Three integer dividers then follow one after another, each dividing by one plus its field. The first gives the bus clock, the second the register-interface clock, and the third the peripheral-timer clock.

A caller sets the fields and pulses `start` along with a 2-bit branch code. The block copies every field, then runs the chain through one restoring divider that produces one quotient bit per clock. All intermediate values are 64 bits wide. When the chain is finished, the block presents a 32-bit result together with a one-cycle `done` pulse. A fractional field of zero on the active path is reported through `err` and gives a result of zero; the block does not divide by it.

Top module: `clk_tree_calc`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy`, `done` and `err` are low and `result` is 0.
- R2: The PLL value is 24,000,000 × 22 when `pll_mul_hi` is 1 and 24,000,000 × 20 when it is 0. With `src_sel` = 0 and all divider fields 0, branch code 1 reports the PLL value.
- R3: `src_sel` picks the peripheral root. Code 0 is the PLL. Code 1 is PLL×18/`frac_b`. Code 2 is PLL×18/`frac_a`. Code 3 is (PLL×18/`frac_b`)/2. Every division truncates.
- R4: bus = root/(1+`bus_div`), reg = bus/(1+`reg_div`), tmr = reg/(1+`tmr_div`), each truncating. Branch code 1 reports reg and branch code 2 reports tmr.
- R5: Branch code 0 reports 0 and branch code 3 reports 32768. For both, `done` rises on the second clock edge after the edge that samples `start`.
- R6: Branch code 1 or 2 with a non-zero `src_sel` whose fraction field is 0 gives `result` 0 with `err` high in the `done` cycle. A zero in the fraction field that the selected source does not use has no effect.
- R7: All fields are sampled on the edge that accepts `start`. Field changes while `busy` is high do not change the result, and a `start` pulse while `busy` is high is ignored (no extra `done`).
- R8: `done` is a single-cycle pulse and `busy` is low during it. `busy` is high from the edge after `start` until `done`, and `result` holds its value between `done` pulses.
- R9: Intermediate values are exact in 64 bits (PLL×18 up to 9,504,000,000). `result` is the low 32 bits of the final value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted when idle |
| clk_sel | input | 2 | Branch code: 0 none, 1 reg clock, 2 timer clock, 3 low-frequency constant |
| pll_mul_hi | input | 1 | PLL multiplier select: 1 gives ×22, 0 gives ×20 |
| src_sel | input | 2 | Peripheral root source code (see R3) |
| frac_a | input | 6 | Fraction field used by source code 2 |
| frac_b | input | 6 | Fraction field used by source codes 1 and 3 |
| bus_div | input | 3 | Bus divider field |
| reg_div | input | 2 | Register-interface divider field |
| tmr_div | input | 6 | Peripheral-timer divider field |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Zero fraction on active path, valid with done |
| result | output | 32 | Computed frequency in Hz |

## Verification
Every stage passes its value to the next, so a wrong quotient bit, a wrong divisor, or a wrong source choice in any stage appears as a wrong `result` at the next `done`. That is within a few hundred cycles of `start`. A stage-sequencing fault that skips or repeats a division gives a value that is off by an integer factor, and branch codes 1 and 2 with distinct divider fields tell such faults apart. A fault in the request control shows as a `done` at the wrong latency for the constant branches, as an extra `done` after a `start` sent while busy, or as a result that follows fields changed during the computation.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
  // branch code on clk_sel
  typedef enum logic [1:0] {
    CSEL_NONE = 2'd0,
    CSEL_REG  = 2'd1,
    CSEL_TMR  = 2'd2,
    CSEL_LOWF = 2'd3
  } csel_e;

  // peripheral root source code on src_sel
  typedef enum logic [1:0] {
    SRC_PLL   = 2'd0,
    SRC_FB    = 2'd1,
    SRC_FA    = 2'd2,
    SRC_FB_HF = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    STG_FRAC,
    STG_BUS,
    STG_REG,
    STG_TMR
  } stg_e;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_PREP,
    FS_LAUNCH,
    FS_WAIT,
    FS_FIN
  } fsm_e;
endpackage

// File: rtl/ctc_pll_stage.sv
// PLL frequency and the fractional-stage numerator, from the latched multiplier select.
module ctc_pll_stage #(
  parameter int DW = 64,
  parameter longint unsigned REF_HZ = 64'd24000000,
  parameter longint unsigned MUL_LO = 64'd20,
  parameter longint unsigned MUL_HI = 64'd22,
  parameter longint unsigned FRAC_NUM = 64'd18
) (
  input  logic          mul_hi,
  output logic [DW-1:0] pll_hz,
  output logic [DW-1:0] frac_prod
);
  localparam logic [DW-1:0] LO_HZ = DW'(REF_HZ * MUL_LO);
  localparam logic [DW-1:0] HI_HZ = DW'(REF_HZ * MUL_HI);
  localparam logic [DW-1:0] NUM   = DW'(FRAC_NUM);

  always_comb begin
    pll_hz    = mul_hi ? HI_HZ : LO_HZ;
    frac_prod = pll_hz * NUM;
  end
endmodule

// File: rtl/ctc_divider.sv
// Restoring divider, one quotient bit per clock, DW iterations per division.
module ctc_divider #(
  parameter int DW = 64,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic [DW-1:0] quotient,
  output logic          done
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] quo;
  logic [VW-1:0] rem;
  logic [CW-1:0] cnt;
  logic          run;
  logic [VW:0]   shifted;
  logic [VW:0]   diff;
  logic          ge;
  logic [VW-1:0] next_rem;

  always_comb begin
    shifted  = {rem, quo[DW-1]};
    ge       = (shifted >= {1'b0, divisor});
    diff     = shifted - {1'b0, divisor};
    next_rem = ge ? diff[VW-1:0] : shifted[VW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quo  <= '0;
      rem  <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        quo <= dividend;
        rem <= '0;
        cnt <= CW'(DW);
        run <= 1'b1;
      end else if (run) begin
        quo <= {quo[DW-2:0], ge};
        rem <= next_rem;
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quotient = quo;
endmodule

// File: rtl/clk_tree_calc.sv
module clk_tree_calc
  import ctc_pkg::*;
#(
  parameter int DW     = 64,
  parameter int RW     = 32,
  parameter int FRAC_W = 6,
  parameter int BUS_W  = 3,
  parameter int REG_W  = 2,
  parameter int TMR_W  = 6,
  parameter longint unsigned REF_HZ   = 64'd24000000,
  parameter longint unsigned MUL_LO   = 64'd20,
  parameter longint unsigned MUL_HI   = 64'd22,
  parameter longint unsigned FRAC_NUM = 64'd18,
  parameter longint unsigned LOWF_HZ  = 64'd32768
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        clk_sel,
  input  logic              pll_mul_hi,
  input  logic [1:0]        src_sel,
  input  logic [FRAC_W-1:0] frac_a,
  input  logic [FRAC_W-1:0] frac_b,
  input  logic [BUS_W-1:0]  bus_div,
  input  logic [REG_W-1:0]  reg_div,
  input  logic [TMR_W-1:0]  tmr_div,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [RW-1:0]     result
);
  // divisor width: widest field plus one bit for the "+1"
  localparam int MW1 = (FRAC_W > TMR_W) ? FRAC_W : TMR_W;
  localparam int MW2 = (MW1 > BUS_W) ? MW1 : BUS_W;
  localparam int DVW = ((MW2 > REG_W) ? MW2 : REG_W) + 1;

  fsm_e              state;
  stg_e              stage;
  csel_e             lat_sel;
  src_e              lat_src;
  logic              lat_hi;
  logic [FRAC_W-1:0] lat_fa, lat_fb;
  logic [BUS_W-1:0]  lat_bus;
  logic [REG_W-1:0]  lat_reg;
  logic [TMR_W-1:0]  lat_tmr;
  logic [DW-1:0]     acc;
  logic              err_n;

  logic [DW-1:0]     pll_hz, frac_prod;
  logic [FRAC_W-1:0] cur_frac;
  logic              div_go, div_done;
  logic [DVW-1:0]    div_den;
  logic [DW-1:0]     div_q;

  ctc_pll_stage #(
    .DW(DW), .REF_HZ(REF_HZ), .MUL_LO(MUL_LO), .MUL_HI(MUL_HI), .FRAC_NUM(FRAC_NUM)
  ) u_pll (
    .mul_hi   (lat_hi),
    .pll_hz   (pll_hz),
    .frac_prod(frac_prod)
  );

  assign cur_frac = (lat_src == SRC_FA) ? lat_fa : lat_fb;
  assign div_go   = (state == FS_LAUNCH);

  always_comb begin
    case (stage)
      STG_FRAC: div_den = DVW'(cur_frac);
      STG_BUS:  div_den = DVW'(lat_bus) + DVW'(1);
      STG_REG:  div_den = DVW'(lat_reg) + DVW'(1);
      default:  div_den = DVW'(lat_tmr) + DVW'(1);
    endcase
  end

  ctc_divider #(.DW(DW), .VW(DVW)) u_div (
    .clk     (clk),
    .rst     (rst),
    .go      (div_go),
    .dividend(acc),
    .divisor (div_den),
    .quotient(div_q),
    .done    (div_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= FS_IDLE;
      stage   <= STG_FRAC;
      lat_sel <= CSEL_NONE;
      lat_src <= SRC_PLL;
      lat_hi  <= 1'b0;
      lat_fa  <= '0;
      lat_fb  <= '0;
      lat_bus <= '0;
      lat_reg <= '0;
      lat_tmr <= '0;
      acc     <= '0;
      err_n   <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      result  <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        FS_IDLE: begin
          if (start) begin
            lat_sel <= csel_e'(clk_sel);
            lat_src <= src_e'(src_sel);
            lat_hi  <= pll_mul_hi;
            lat_fa  <= frac_a;
            lat_fb  <= frac_b;
            lat_bus <= bus_div;
            lat_reg <= reg_div;
            lat_tmr <= tmr_div;
            err_n   <= 1'b0;
            busy    <= 1'b1;
            state   <= FS_PREP;
          end
        end
        FS_PREP: begin
          if (lat_sel == CSEL_NONE) begin
            acc   <= '0;
            state <= FS_FIN;
          end else if (lat_sel == CSEL_LOWF) begin
            acc   <= DW'(LOWF_HZ);
            state <= FS_FIN;
          end else if (lat_src == SRC_PLL) begin
            acc   <= pll_hz;
            stage <= STG_BUS;
            state <= FS_LAUNCH;
          end else if (cur_frac == '0) begin
            acc   <= '0;
            err_n <= 1'b1;
            state <= FS_FIN;
          end else begin
            acc   <= frac_prod;
            stage <= STG_FRAC;
            state <= FS_LAUNCH;
          end
        end
        FS_LAUNCH: state <= FS_WAIT;
        FS_WAIT: begin
          if (div_done) begin
            case (stage)
              STG_FRAC: begin
                acc   <= (lat_src == SRC_FB_HF) ? (div_q >> 1) : div_q;
                stage <= STG_BUS;
                state <= FS_LAUNCH;
              end
              STG_BUS: begin
                acc   <= div_q;
                stage <= STG_REG;
                state <= FS_LAUNCH;
              end
              STG_REG: begin
                acc <= div_q;
                if (lat_sel == CSEL_TMR) begin
                  stage <= STG_TMR;
                  state <= FS_LAUNCH;
                end else begin
                  state <= FS_FIN;
                end
              end
              default: begin
                acc   <= div_q;
                state <= FS_FIN;
              end
            endcase
          end
        end
        FS_FIN: begin
          result <= acc[RW-1:0];
          done   <= 1'b1;
          err    <= err_n;
          busy   <= 1'b0;
          state  <= FS_IDLE;
        end
        default: state <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ctc_checks.sv
module ctc_checks #(
  parameter int RW  = 32,
  parameter int DVW = 7
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           err,
  input logic [RW-1:0]  result,
  input logic           div_go,
  input logic [DVW-1:0] div_den,
  input logic [1:0]     lat_sel
);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_idle_at_done_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done |=> ($stable(result) || done));

  p_err_with_done_r6: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  p_no_zero_divisor_r6: assert property (@(posedge clk) disable iff (rst)
    div_go |-> (div_den != '0));

  p_none_gives_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (done && lat_sel == 2'd0) |-> (result == '0));

  p_busy_start_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));
endmodule

bind clk_tree_calc ctc_checks #(.RW(RW), .DVW(DVW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .err    (err),
  .result (result),
  .div_go (div_go),
  .div_den(div_den),
  .lat_sel(lat_sel)
);

// File: tb/sim_clk_tree_calc.sv
module sim_clk_tree_calc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  csel = 2'd0;
  logic        mhi = 1'b0;
  logic [1:0]  src = 2'd0;
  logic [5:0]  fa = 6'd0;
  logic [5:0]  fb = 6'd0;
  logic [2:0]  bdv = 3'd0;
  logic [1:0]  rdv = 2'd0;
  logic [5:0]  tdv = 6'd0;
  logic        busy, done, err;
  logic [31:0] result;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  clk_tree_calc u0 (
    .clk(clk), .rst(rst), .start(start), .clk_sel(csel), .pll_mul_hi(mhi),
    .src_sel(src), .frac_a(fa), .frac_b(fb), .bus_div(bdv), .reg_div(rdv),
    .tmr_div(tdv), .busy(busy), .done(done), .err(err), .result(result)
  );

  // expected {err, result} from the requirements
  function automatic logic [32:0] model(input logic [1:0] s, input logic [1:0] sr,
      input logic mh, input logic [5:0] a, input logic [5:0] b, input logic [2:0] bd,
      input logic [1:0] rd, input logic [5:0] td);
    logic [63:0] f, fr;
    if (s == 2'd0) return 33'd0;
    if (s == 2'd3) return {1'b0, 32'd32768};
    f = mh ? 64'd528000000 : 64'd480000000;
    if (sr != 2'd0) begin
      fr = (sr == 2'd2) ? {58'd0, a} : {58'd0, b};
      if (fr == 64'd0) return {1'b1, 32'd0};
      f = (f * 64'd18) / fr;
      if (sr == 2'd3) f = f / 64'd2;
    end
    f = f / ({61'd0, bd} + 64'd1);
    f = f / ({62'd0, rd} + 64'd1);
    if (s == 2'd2) f = f / ({58'd0, td} + 64'd1);
    return {1'b0, f[31:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] s, input logic [1:0] sr, input logic mh,
      input logic [5:0] a, input logic [5:0] b, input logic [2:0] bd,
      input logic [1:0] rd, input logic [5:0] td);
    @(negedge clk);
    csel = s; src = sr; mhi = mh; fa = a; fb = b; bdv = bd; rdv = rd; tdv = td;
  endtask

  // pulse start and wait for done; lat counts negedges after the start negedge
  task automatic run(output logic [31:0] r, output logic e, output int lat, output logic busy_seen);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    busy_seen = busy;
    while (!done && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
    r = result;
    e = err;
  endtask

  task automatic do_case(input string tag, input logic [1:0] s, input logic [1:0] sr,
      input logic mh, input logic [5:0] a, input logic [5:0] b, input logic [2:0] bd,
      input logic [1:0] rd, input logic [5:0] td);
    logic [31:0] r;
    logic e, bs;
    int lat;
    logic [32:0] x;
    x = model(s, sr, mh, a, b, bd, rd, td);
    set_cfg(s, sr, mh, a, b, bd, rd, td);
    run(r, e, lat, bs);
    check(r == x[31:0], {tag, " result"}, {32'd0, r}, {32'd0, x[31:0]});
    check(e == x[32], {tag, " err"}, {63'd0, e}, {63'd0, x[32]});
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(!busy && !done && !err, "R1 flags in reset", {61'd0, busy, done, err}, 64'd0);
    check(result == 32'd0, "R1 result in reset", {32'd0, result}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !err && result == 32'd0, "R1 after release",
          {61'd0, busy, done, err}, 64'd0);
  endtask

  task automatic t_pll;
    do_case("R2 pll x20", 2'd1, 2'd0, 1'b0, 6'd10, 6'd10, 3'd0, 2'd0, 6'd0);
    do_case("R2 pll x22", 2'd1, 2'd0, 1'b1, 6'd10, 6'd10, 3'd0, 2'd0, 6'd0);
  endtask

  task automatic t_frac;
    do_case("R3 src1 frac_b", 2'd1, 2'd1, 1'b1, 6'd27, 6'd24, 3'd0, 2'd0, 6'd0);
    do_case("R3 src2 frac_a", 2'd1, 2'd2, 1'b1, 6'd27, 6'd24, 3'd0, 2'd0, 6'd0);
    do_case("R3 src3 half", 2'd1, 2'd3, 1'b0, 6'd27, 6'd35, 3'd0, 2'd0, 6'd0);
    do_case("R3 truncation", 2'd1, 2'd1, 1'b1, 6'd5, 6'd7, 3'd0, 2'd0, 6'd0);
  endtask

  task automatic t_chain;
    do_case("R4 reg branch", 2'd1, 2'd1, 1'b1, 6'd27, 6'd24, 3'd3, 2'd1, 6'd5);
    do_case("R4 tmr branch", 2'd2, 2'd1, 1'b1, 6'd27, 6'd24, 3'd3, 2'd1, 6'd5);
    do_case("R4 max dividers", 2'd2, 2'd2, 1'b0, 6'd19, 6'd24, 3'd7, 2'd3, 6'd63);
    do_case("R4 odd chain", 2'd2, 2'd0, 1'b1, 6'd0, 6'd0, 3'd2, 2'd2, 6'd6);
  endtask

  task automatic t_fast;
    logic [31:0] r;
    logic e, bs;
    int lat;
    set_cfg(2'd0, 2'd1, 1'b1, 6'd27, 6'd24, 3'd3, 2'd1, 6'd5);
    run(r, e, lat, bs);
    check(r == 32'd0, "R5 none result", {32'd0, r}, 64'd0);
    check(lat == 3, "R5 none latency", lat, 64'd3);
    set_cfg(2'd3, 2'd1, 1'b1, 6'd27, 6'd24, 3'd3, 2'd1, 6'd5);
    run(r, e, lat, bs);
    check(r == 32'd32768, "R5 low-freq result", {32'd0, r}, 64'd32768);
    check(lat == 3, "R5 low-freq latency", lat, 64'd3);
  endtask

  task automatic t_zero;
    do_case("R6 zero frac_b used", 2'd1, 2'd1, 1'b1, 6'd27, 6'd0, 3'd1, 2'd1, 6'd0);
    do_case("R6 zero frac_a used", 2'd2, 2'd2, 1'b0, 6'd0, 6'd24, 3'd1, 2'd1, 6'd3);
    do_case("R6 zero frac_b unused", 2'd1, 2'd2, 1'b1, 6'd27, 6'd0, 3'd1, 2'd1, 6'd0);
    do_case("R6 zero frac on pll src", 2'd2, 2'd0, 1'b1, 6'd0, 6'd0, 3'd1, 2'd0, 6'd1);
  endtask

  task automatic t_latch;
    logic [32:0] x;
    int dones;
    int lat;
    x = model(2'd2, 2'd1, 1'b1, 6'd27, 6'd24, 3'd3, 2'd1, 6'd5);
    set_cfg(2'd2, 2'd1, 1'b1, 6'd27, 6'd24, 3'd3, 2'd1, 6'd5);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    // busy now: change every field and send a second request
    csel = 2'd0; src = 2'd2; mhi = 1'b0; fa = 6'd0; fb = 6'd3; bdv = 3'd0; rdv = 2'd0; tdv = 6'd0;
    check(busy == 1'b1, "R8 busy after start", {63'd0, busy}, 64'd1);
    @(negedge clk);
    start = 1'b0;
    lat = 2;
    while (!done && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
    check(result == x[31:0], "R7 fields latched at start", {32'd0, result}, {32'd0, x[31:0]});
    check(lat > 3, "R7 busy start ignored latency", lat, 64'd4);
    dones = 0;
    repeat (400) begin
      @(negedge clk);
      if (done) dones++;
    end
    check(dones == 0, "R7 no extra done", dones, 64'd0);
  endtask

  task automatic t_hold;
    logic [31:0] r;
    logic e, bs;
    int lat;
    set_cfg(2'd1, 2'd3, 1'b1, 6'd1, 6'd9, 3'd2, 2'd1, 6'd0);
    run(r, e, lat, bs);
    check(bs == 1'b1, "R8 busy during request", {63'd0, bs}, 64'd1);
    check(busy == 1'b0, "R8 busy low at done", {63'd0, busy}, 64'd0);
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", {63'd0, done}, 64'd0);
    set_cfg(2'd3, 2'd0, 1'b0, 6'd0, 6'd0, 3'd0, 2'd0, 6'd0);
    repeat (5) @(negedge clk);
    check(result == r, "R8 result held", {32'd0, result}, {32'd0, r});
  endtask

  task automatic t_wide;
    do_case("R9 largest product", 2'd1, 2'd1, 1'b1, 6'd5, 6'd1, 3'd7, 2'd3, 6'd0);
    do_case("R9 low 32 bits", 2'd1, 2'd1, 1'b1, 6'd5, 6'd1, 3'd0, 2'd0, 6'd0);
  endtask

  initial begin
    wait (cyc > 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
    $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_pll();
    t_frac();
    t_chain();
    t_fast();
    t_zero();
    t_latch();
    t_hold();
    t_wide();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule